// File: doc/BRIEF.md
# Non-volatile memory access controller

This block sits between a small CPU bus and an on-chip byte array that stands in for an EEPROM. Software reaches three registers through a two-bit select: a control register, an address register and a data register. Reads from the array are a single access: the byte lands in the data register on the next clock. Programming is guarded by a timed unlock. Software first arms a master enable bit. This bit clears itself after a fixed number of cycles. The program strobe takes effect only while that bit is still set.

A started write runs for a time that depends on its mode. The mode is one of erase-then-write, erase only, or write only, and each has its own cycle count. The program bit stays set for that time and serves as a busy flag. While a write is busy, read requests and address changes are refused. The block stalls the CPU for a fixed number of cycles on each accepted access. It also raises a level ready interrupt whenever the interrupt is enabled, global interrupts are on, and no write is in progress. The array is a synchronous RAM that comes out of reset erased, and a down counter models its write time.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the control, address and data registers read as zero, `cpu_stall` and `ready_irq` are low, and every array byte reads 0xFF.
- R2: Writing 1 to control bit 2 (master enable) makes it read as 1 for exactly ARM_CYCLES cycles, after which hardware clears it. Writing it again while it is set restarts the window.
- R3: Writing 1 to control bit 1 (program) while control bit 2 is clear has no effect. The program bit stays 0, no stall occurs and the array is unchanged.
- R4: Writing 1 to control bit 1 while bit 2 is set and no write is busy starts a write to the address register's byte and clears bit 2. Bit 1 then reads 1 for exactly the mode's duration (T_ERASE_WRITE, T_ERASE or T_WRITE cycles), then 0.
- R5: The write mode is taken from control bits 5:4 of the starting bus write. Mode 00 stores the data byte. Mode 01 stores 0xFF. Mode 10 stores the old byte AND the data byte.
- R6: An accepted write start holds `cpu_stall` high for exactly WR_STALL cycles.
- R7: Writing 1 to control bit 0 (read) while idle loads the data register with the addressed byte on the next cycle. It also holds `cpu_stall` high for RD_STALL cycles. Bit 0 reads 1 for that one cycle only.
- R8: While a write is busy, a read request changes neither the data register nor `cpu_stall`, and a bus write to the address register is dropped.
- R9: The byte written is the data register's value when the write starts. Bus writes to the data register during the busy time do not change it.
- R10: `ready_irq` equals control bit 3 AND `gie` AND not busy, as a continuous level.
- R11: A single control write that sets both program and read while idle and armed starts the write and drops the read.
- R12: A program request while a write is busy is ignored. It does not restart the write, change its duration or change its mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| gie | input | 1 | Global interrupt enable from the CPU |
| cpu_stall | output | 1 | Holds the CPU while high |
| ready_irq | output | 1 | Level ready interrupt request |

## Verification
Writes are tried in all three modes on one address that holds a known value. This lets plain store, erase and AND-merge be told apart by the byte read back. Each write's busy time is measured in cycles against its own mode's duration. The program strobe is placed on the last cycle of the unlock window and on the first cycle after it, which separates an off-by-one window from a correct one. Busy-time traffic (address, data, read and a second program request) shows that each is blocked or decoupled. The final byte and the unchanged duration show that no second write slipped in.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PGM_ERASE_WRITE = 2'd0,
        PGM_ERASE       = 2'd1,
        PGM_WRITE       = 2'd2,
        PGM_RSVD        = 2'd3
    } pgm_mode_e;

    // control register bit positions
    localparam int CB_RD   = 0;
    localparam int CB_PG   = 1;
    localparam int CB_MS   = 2;
    localparam int CB_IE   = 3;
    localparam int CB_MODE = 4;

endpackage

// File: rtl/nvm_countdown.sv
module nvm_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         active
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count  = cnt_q;
    assign active = (cnt_q != '0);

endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // model starts erased; a write lands at the end of the busy time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int DATA_W        = 8,
    parameter int ARM_CYCLES    = 4,
    parameter int WR_STALL      = 2,
    parameter int RD_STALL      = 4,
    parameter int T_ERASE_WRITE = 12,
    parameter int T_ERASE       = 8,
    parameter int T_WRITE       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gie,
    output logic              cpu_stall,
    output logic              ready_irq
);

    localparam int T_PGM_MAX = (T_ERASE_WRITE > T_ERASE)
                             ? ((T_ERASE_WRITE > T_WRITE) ? T_ERASE_WRITE : T_WRITE)
                             : ((T_ERASE > T_WRITE) ? T_ERASE : T_WRITE);
    localparam int T_AUX_MAX = (ARM_CYCLES > WR_STALL)
                             ? ((ARM_CYCLES > RD_STALL) ? ARM_CYCLES : RD_STALL)
                             : ((WR_STALL > RD_STALL) ? WR_STALL : RD_STALL);
    localparam int T_MAX     = (T_PGM_MAX > T_AUX_MAX) ? T_PGM_MAX : T_AUX_MAX;
    localparam int CNT_W     = $clog2(T_MAX + 1);
    localparam int CTRL_W    = CB_MODE + 2;

    typedef struct packed {
        logic              irq_en;
        logic [1:0]        mode;
        logic              rd_flag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] wcap;
        pgm_mode_e         mcap;
    } state_t;

    state_t st_d, st_q;

    logic              ctrl_wr, addr_wr, data_wr;
    logic              pg_req, rd_req, ms_req;
    logic              start, do_read, commit;
    logic              busy, master;
    logic [CNT_W-1:0]  busy_cnt, arm_cnt, stall_cnt;
    logic [CNT_W-1:0]  dur, arm_val, stall_val;
    logic              arm_load, stall_load;
    pgm_mode_e         req_mode;
    logic [DATA_W-1:0] arr_rdata, arr_wdata;

    // ---------------- request decode ----------------
    always_comb begin
        ctrl_wr  = bus_wr && (bus_sel == SEL_CTRL);
        addr_wr  = bus_wr && (bus_sel == SEL_ADDR);
        data_wr  = bus_wr && (bus_sel == SEL_DATA);
        pg_req   = ctrl_wr && bus_wdata[CB_PG];
        rd_req   = ctrl_wr && bus_wdata[CB_RD];
        ms_req   = ctrl_wr && bus_wdata[CB_MS];
        req_mode = pgm_mode_e'(bus_wdata[CB_MODE +: 2]);
        start    = pg_req && master && !busy;
        do_read  = rd_req && !busy && !start;
        commit   = busy && (busy_cnt == CNT_W'(1));
    end

    always_comb begin
        unique case (req_mode)
            PGM_ERASE: dur = CNT_W'(T_ERASE);
            PGM_WRITE: dur = CNT_W'(T_WRITE);
            default:   dur = CNT_W'(T_ERASE_WRITE);
        endcase
        arm_load   = start || ms_req;
        arm_val    = start ? '0 : CNT_W'(ARM_CYCLES);
        stall_load = start || do_read;
        stall_val  = start ? CNT_W'(WR_STALL) : CNT_W'(RD_STALL);
    end

    // ---------------- timers ----------------
    nvm_countdown #(.W(CNT_W)) arm_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(arm_load), .load_val(arm_val),
        .count(arm_cnt), .active(master)
    );

    nvm_countdown #(.W(CNT_W)) busy_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(start), .load_val(dur),
        .count(busy_cnt), .active(busy)
    );

    nvm_countdown #(.W(CNT_W)) stall_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(stall_load), .load_val(stall_val),
        .count(stall_cnt), .active(cpu_stall)
    );

    // ---------------- array ----------------
    always_comb begin
        unique case (st_q.mcap)
            PGM_ERASE: arr_wdata = '1;
            PGM_WRITE: arr_wdata = arr_rdata & st_q.wcap;
            default:   arr_wdata = st_q.wcap;
        endcase
    end

    nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk), .rst_n(rst_n), .we(commit), .addr(st_q.addr),
        .wdata(arr_wdata), .rdata(arr_rdata)
    );

    // ---------------- register next state ----------------
    always_comb begin
        st_d         = st_q;
        st_d.rd_flag = do_read;
        if (ctrl_wr) begin
            st_d.irq_en = bus_wdata[CB_IE];
            st_d.mode   = bus_wdata[CB_MODE +: 2];
        end
        if (addr_wr && !busy) begin
            st_d.addr = bus_wdata[ADDR_W-1:0];
        end
        if (do_read) begin
            st_d.data = arr_rdata;
        end else if (data_wr) begin
            st_d.data = bus_wdata;
        end
        if (start) begin
            st_d.wcap = st_q.data;
            st_d.mcap = req_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_sel))
            SEL_CTRL: bus_rdata[CTRL_W-1:0] = {st_q.mode, st_q.irq_en, master, busy, st_q.rd_flag};
            SEL_ADDR: bus_rdata[ADDR_W-1:0] = st_q.addr;
            SEL_DATA: bus_rdata             = st_q.data;
            default:  bus_rdata             = '0;
        endcase
    end

    assign ready_irq = st_q.irq_en && gie && !busy;

    logic unused_ok;
    assign unused_ok = ^{bus_wdata, arm_cnt, stall_cnt};

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
    parameter int ADDR_W     = 6,
    parameter int ARM_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_req,
    input logic              master,
    input logic              prog,
    input logic              rd_flag,
    input logic              stall,
    input logic              irq,
    input logic [ADDR_W-1:0] addr
);

    int arm_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_run_q <= 0;
        end else if (arm_req) begin
            arm_run_q <= 0;
        end else if (master && arm_run_q < ARM_CYCLES) begin
            arm_run_q <= arm_run_q + 1;
        end else if (!master) begin
            arm_run_q <= 0;
        end
    end

    // R2: master enable never outlives its window
    a_r2_master_window: assert property (@(posedge clk) disable iff (!rst_n)
        master |-> (arm_run_q < ARM_CYCLES));

    // R4: a write only starts when the unlock was armed
    a_r4_start_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog) |-> $past(master));

    // R6: a write start stalls the CPU
    a_r6_stall_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog) |-> stall);

    // R7: a read stalls the CPU
    a_r7_stall_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_flag) |-> stall);

    // R8: address frozen while busy
    a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (prog && $past(prog)) |-> $stable(addr));

    // R8: no read accepted while busy
    a_r8_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog |-> !rd_flag);

    // R10: interrupt silent while busy
    a_r10_irq_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog |-> !irq);

endmodule

bind nvm_ctrl nvm_ctrl_chk #(.ADDR_W(ADDR_W), .ARM_CYCLES(ARM_CYCLES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_req (ms_req),
    .master  (master),
    .prog    (busy),
    .rd_flag (st_q.rd_flag),
    .stall   (cpu_stall),
    .irq     (ready_irq),
    .addr    (st_q.addr)
);

// File: tb/nvm_ctrl_tb_top.sv
module nvm_ctrl_tb_top;
    import nvm_ctrl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int ARM = 4;
    localparam int WS  = 2;
    localparam int RS  = 4;
    localparam int TEW = 12;
    localparam int TE  = 8;
    localparam int TW  = 6;

    localparam logic [7:0] B_RD = 8'h01;
    localparam logic [7:0] B_PG = 8'h02;
    localparam logic [7:0] B_MS = 8'h04;
    localparam logic [7:0] B_IE = 8'h08;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_sel = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          gie = 1'b0;
    logic          cpu_stall;
    logic          ready_irq;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    logic [7:0] ie_bit = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nvm_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ARM_CYCLES(ARM), .WR_STALL(WS), .RD_STALL(RS),
               .T_ERASE_WRITE(TEW), .T_ERASE(TE), .T_WRITE(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
        .cpu_stall(cpu_stall), .ready_irq(ready_irq)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(logic [1:0] sel, output logic [7:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
    endtask

    task automatic start_write(logic [1:0] mode, logic [7:0] a, logic [7:0] d);
        wr(SEL_ADDR, a);
        wr(SEL_DATA, d);
        wr(SEL_CTRL, ie_bit | B_MS);
        wr(SEL_CTRL, ie_bit | B_PG | {2'b00, mode, 4'h0});
    endtask

    task automatic wait_idle(int c0, output int n);
        logic [7:0] v;
        for (int k = 0; k < 1000; k++) begin
            peek(SEL_CTRL, v);
            if (!v[1]) break;
            @(negedge clk);
        end
        n = cyc - c0;
    endtask

    task automatic read_mem(logic [7:0] a, output logic [7:0] v);
        wr(SEL_ADDR, a);
        wr(SEL_CTRL, ie_bit | B_RD);
        peek(SEL_DATA, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        gie = 1'b1;
        peek(SEL_CTRL, v); check("R1", "ctrl", v, 0);
        peek(SEL_ADDR, v); check("R1", "addr", v, 0);
        peek(SEL_DATA, v); check("R1", "data", v, 0);
        check("R1", "stall", cpu_stall, 0);
        check("R1", "irq", ready_irq, 0);
        read_mem(8'd3, v); check("R1", "erased byte", v, 8'hFF);
    endtask

    task automatic t_write_basic();
        logic [7:0] v;
        int c0, n;
        start_write(PGM_ERASE_WRITE, 8'd5, 8'hA5);
        c0 = cyc;
        peek(SEL_CTRL, v);
        check("R4", "prog set", v[1], 1);
        check("R4", "master consumed", v[2], 0);
        check("R6", "stall cycle0", cpu_stall, 1);
        @(negedge clk); check("R6", "stall cycle1", cpu_stall, 1);
        @(negedge clk); check("R6", "stall released", cpu_stall, 0);
        wait_idle(c0, n); check("R4", "erase-write duration", n, TEW);
        read_mem(8'd5, v); check("R5", "mode00 store", v, 8'hA5);
    endtask

    task automatic t_read();
        logic [7:0] v;
        wr(SEL_ADDR, 8'd5);
        wr(SEL_DATA, 8'h00);
        wr(SEL_CTRL, B_RD);
        peek(SEL_DATA, v); check("R7", "data loaded", v, 8'hA5);
        peek(SEL_CTRL, v); check("R7", "rd bit first", v[0], 1);
        check("R7", "stall c0", cpu_stall, 1);
        @(negedge clk); peek(SEL_CTRL, v); check("R7", "rd bit cleared", v[0], 0);
        check("R7", "stall c1", cpu_stall, 1);
        @(negedge clk); check("R7", "stall c2", cpu_stall, 1);
        @(negedge clk); check("R7", "stall c3", cpu_stall, 1);
        @(negedge clk); check("R7", "stall released", cpu_stall, 0);
    endtask

    task automatic t_modes();
        logic [7:0] v;
        int c0, n;
        start_write(PGM_ERASE, 8'd5, 8'h12); c0 = cyc;
        wait_idle(c0, n); check("R4", "erase duration", n, TE);
        read_mem(8'd5, v); check("R5", "mode01 erase", v, 8'hFF);
        start_write(PGM_WRITE, 8'd5, 8'h3C); c0 = cyc;
        wait_idle(c0, n); check("R4", "write-only duration", n, TW);
        read_mem(8'd5, v); check("R5", "mode10 and from ff", v, 8'h3C);
        start_write(PGM_WRITE, 8'd5, 8'h0F); c0 = cyc;
        wait_idle(c0, n);
        read_mem(8'd5, v); check("R5", "mode10 and merge", v, 8'h0C);
    endtask

    task automatic t_unlock();
        logic [7:0] v;
        int c0, n;
        // program with no arming
        wr(SEL_DATA, 8'h00);
        wr(SEL_CTRL, B_PG);
        peek(SEL_CTRL, v); check("R3", "unarmed prog", v[1], 0);
        check("R3", "unarmed stall", cpu_stall, 0);
        // window length
        wr(SEL_CTRL, B_MS);
        for (int i = 0; i < ARM; i++) begin
            peek(SEL_CTRL, v); check("R2", "master held", v[2], 1);
            @(negedge clk);
        end
        peek(SEL_CTRL, v); check("R2", "master self-clear", v[2], 0);
        // strobe one cycle late: rejected
        wr(SEL_CTRL, B_MS);
        repeat (3) @(negedge clk);
        wr(SEL_CTRL, B_PG);
        peek(SEL_CTRL, v); check("R3", "late prog", v[1], 0);
        read_mem(8'd5, v); check("R3", "array unchanged", v, 8'h0C);
        // strobe on last armed cycle: accepted
        wr(SEL_CTRL, B_MS);
        repeat (2) @(negedge clk);
        wr(SEL_CTRL, B_PG | {2'b00, PGM_ERASE, 4'h0});
        c0 = cyc;
        peek(SEL_CTRL, v); check("R2", "last window cycle accepted", v[1], 1);
        wait_idle(c0, n);
        read_mem(8'd5, v); check("R2", "boundary erase done", v, 8'hFF);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        int c0, n;
        ie_bit = B_IE; gie = 1'b1;
        wr(SEL_CTRL, ie_bit);
        check("R10", "irq idle", ready_irq, 1);
        start_write(PGM_ERASE_WRITE, 8'd7, 8'h5A); c0 = cyc;
        check("R10", "irq busy", ready_irq, 0);
        wr(SEL_ADDR, 8'd9);
        peek(SEL_ADDR, v); check("R8", "addr blocked", v, 7);
        wr(SEL_DATA, 8'h11);
        peek(SEL_DATA, v); check("R9", "data reg written", v, 8'h11);
        wr(SEL_CTRL, ie_bit | B_RD);
        peek(SEL_DATA, v); check("R8", "read ignored data", v, 8'h11);
        check("R8", "read ignored stall", cpu_stall, 0);
        wr(SEL_CTRL, ie_bit | B_MS);
        wr(SEL_CTRL, ie_bit | B_PG | {2'b00, PGM_ERASE, 4'h0});
        check("R12", "second prog no stall", cpu_stall, 0);
        wait_idle(c0, n); check("R12", "duration unchanged", n, TEW);
        check("R10", "irq after done", ready_irq, 1);
        read_mem(8'd7, v); check("R9", "captured data stored", v, 8'h5A);
        wr(SEL_ADDR, 8'd9);
        peek(SEL_ADDR, v); check("R8", "addr write when idle", v, 9);
        ie_bit = 8'h00;
        wr(SEL_CTRL, ie_bit);
        check("R10", "irq disabled", ready_irq, 0);
        ie_bit = B_IE;
        wr(SEL_CTRL, ie_bit);
        gie = 1'b0; #1;
        check("R10", "irq gie low", ready_irq, 0);
        ie_bit = 8'h00;
        wr(SEL_CTRL, ie_bit);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        int c0, n;
        wr(SEL_ADDR, 8'd7);
        wr(SEL_DATA, 8'h77);
        wr(SEL_CTRL, B_MS);
        wr(SEL_CTRL, B_PG | B_RD | {2'b00, PGM_ERASE, 4'h0});
        c0 = cyc;
        peek(SEL_CTRL, v);
        check("R11", "write started", v[1], 1);
        check("R11", "read dropped", v[0], 0);
        peek(SEL_DATA, v); check("R11", "data untouched", v, 8'h77);
        wait_idle(c0, n);
        peek(SEL_DATA, v); check("R11", "data after write", v, 8'h77);
        read_mem(8'd7, v); check("R11", "erase applied", v, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_read();
        t_modes();
        t_unlock();
        t_busy();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule